// File: doc/BRIEF.md
# Multi-Mode Input Noise Filter

This block cleans up one asynchronous digital input before later logic uses its edges to raise service requests. The raw pin first goes through a flop synchronizer. A prescaler then makes a filter tick once every 2, 4, 8, 16, 32, 64, 128 or 256 system clocks. Depending on a 2-bit mode field, the filtered level follows the synchronized input in one of four ways:
- it changes only when two tick samples in a row agree;
- it changes only when three tick samples in a row agree;
- it changes only when every sample taken at half the system rate, across a whole tick period, held one value;
- in bypass, it follows the synchronized input at once.

Each change of the filtered level comes with a one-clock rising or falling strobe. If software rewrites the mode or the prescale field, the collected history is discarded. Old samples therefore never combine with the new policy to produce a false transition. The block suits timer and capture channels whose pins see short noise spikes. Such a channel trades edge latency against noise immunity by picking a mode and a tick rate.

Top module: `pin_noise_filter`

## Requirements
- R1: The filter tick period is 2^(code+1) system clocks, where code is the 3-bit `prescale_sel` value (0 gives 2, 7 gives 256). After reset or a configuration change, the first tick falls on the edge that is one full period after the restart.
- R2: `din_raw` passes through two synchronizer flops. A sample taken on a given edge sees an input change that was driven three or more edges earlier.
- R3: In two-sample mode (`mode_sel` = 00), `filt_level` takes a new value only on a tick edge. The sample on that tick must equal the sample on the previous tick and differ from the current level.
- R4: In three-sample mode (`mode_sel` = 01), `filt_level` takes a new value only on a tick whose sample matches the two tick samples before it. A pulse that spans only two ticks is rejected.
- R5: In continuous mode (`mode_sel` = 10), the input is also sampled on every second system clock. The level updates at a tick only if all those samples, from the previous tick through the current one, held one value. With a clean step, the latency equals that of two-sample mode.
- R6: In continuous mode, a single noise sample between ticks moves the detection of a real transition out by at least one further tick period.
- R7: In bypass (`mode_sel` = 11), `filt_level` equals the synchronized input one clock later, with no filtering.
- R8: In two-sample mode at prescale code 0, a pulse lasting one system clock never reaches `filt_level`, while a pulse lasting four system clocks always does.
- R9: During and after reset, `filt_level`, `rise_pulse` and `fall_pulse` are 0, and all sample history is empty.
- R10: Each change of `filt_level` is reported on the same cycle by exactly one one-clock strobe: `rise_pulse` for 0 to 1, `fall_pulse` for 1 to 0. The two strobes are never high together.
- R11: On the edge after `mode_sel` or `prescale_sel` changes, the prescaler restarts and the sample history and the stability flag are cleared. An update then needs a full new set of samples taken under the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din_raw | input | 1 | Asynchronous input to be filtered |
| mode_sel | input | 2 | Filter policy: 00 two-sample, 01 three-sample, 10 continuous, 11 bypass |
| prescale_sel | input | PS_W (3) | Tick period code, period = 2^(code+1) clocks |
| filt_level | output | 1 | Registered filtered level |
| rise_pulse | output | 1 | One-clock strobe on a 0 to 1 change of `filt_level` |
| fall_pulse | output | 1 | One-clock strobe on a 1 to 0 change of `filt_level` |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and a 3-bit prescale field, so divides up to 256 are possible. It drives only prescale codes 0 to 3 (periods 2 to 16). This keeps every pulse and noise placement a few dozen clocks long. It still brings within reach the divide-by-2 glitch bound, the two-tick pulse that three-sample mode rejects, and a noise sample placed on a half-rate edge between ticks. Switching the period while a sample is pending exposes whether stale history survives a configuration change.

// File: rtl/pnf_pkg.sv
package pnf_pkg;

  typedef enum logic [1:0] {
    FM_TWO    = 2'b00,
    FM_THREE  = 2'b01,
    FM_CONT   = 2'b10,
    FM_BYPASS = 2'b11
  } filt_mode_e;

endpackage

// File: rtl/pnf_sync.sv
module pnf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];

endmodule

// File: rtl/pnf_prescaler.sv
module pnf_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick,
  output logic            half
);

  localparam int CNT_W = 1 << PS_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   div_full;
  logic [CNT_W:0]   limit;

  always_comb begin
    div_full = (CNT_W+1)'(1) << ({1'b0, ps_sel} + 1'b1);
    limit    = div_full - 1'b1;
  end

  assign tick = (cnt == limit[CNT_W-1:0]);
  assign half = cnt[0];

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R1
  half_alt_chk: assert property (@(posedge clk) disable iff (rst)
    half |=> !half);

  // R1
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));

endmodule

// File: rtl/pnf_decider.sv
module pnf_decider
  import pnf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  filt_mode_e mode,
  input  logic       tick,
  input  logic       half,
  input  logic       samp,
  output logic       state,
  output logic       rise,
  output logic       fall
);

  logic       h0, h1;
  logic [1:0] nvalid;
  logic       ok;
  logic       upd;
  logic       changing;

  always_comb begin
    upd = 1'b0;
    unique case (mode)
      FM_TWO:    upd = tick && (nvalid != 2'd0) && (samp == h0);
      FM_THREE:  upd = tick && (nvalid == 2'd2) && (samp == h0) && (samp == h1);
      FM_CONT:   upd = tick && (nvalid != 2'd0) && ok && (samp == h0);
      FM_BYPASS: upd = 1'b1;
      default:   upd = 1'b0;
    endcase
    changing = upd && !clr && (samp != state);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
      h0     <= 1'b0;
      h1     <= 1'b0;
      nvalid <= 2'd0;
      ok     <= 1'b0;
    end else begin
      rise <= changing && samp;
      fall <= changing && !samp;
      if (changing) state <= samp;
      if (clr) begin
        h0     <= 1'b0;
        h1     <= 1'b0;
        nvalid <= 2'd0;
        ok     <= 1'b0;
      end else if (tick) begin
        h1     <= h0;
        h0     <= samp;
        nvalid <= (nvalid == 2'd2) ? 2'd2 : nvalid + 2'd1;
        ok     <= 1'b1;
      end else if (half) begin
        ok <= ok && (samp == h0);
      end
    end
  end

  // R3
  upd_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(state) && ($past(mode) != FM_BYPASS)) |-> $past(tick));

  // R4
  three_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(state) && ($past(mode) == FM_THREE)) |-> (($past(h0) == state) && ($past(h1) == state)));

  // R11
  hist_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> ((nvalid == 2'd0) && !ok));

endmodule

// File: rtl/pin_noise_filter.sv
module pin_noise_filter
  import pnf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din_raw,
  input  logic [1:0]      mode_sel,
  input  logic [PS_W-1:0] prescale_sel,
  output logic            filt_level,
  output logic            rise_pulse,
  output logic            fall_pulse
);

  localparam int CFG_W = 2 + PS_W;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             sync_q;
  logic             tick;
  logic             half;

  assign cfg_chg = ({mode_sel, prescale_sel} != cfg_q);

  always_ff @(posedge clk) begin
    cfg_q <= {mode_sel, prescale_sel};
  end

  pnf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (din_raw),
    .dout (sync_q)
  );

  pnf_prescaler #(.PS_W(PS_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_chg),
    .ps_sel  (prescale_sel),
    .tick    (tick),
    .half    (half)
  );

  pnf_decider u_dec (
    .clk   (clk),
    .rst   (rst),
    .clr   (cfg_chg),
    .mode  (filt_mode_e'(mode_sel)),
    .tick  (tick),
    .half  (half),
    .samp  (sync_q),
    .state (filt_level),
    .rise  (rise_pulse),
    .fall  (fall_pulse)
  );

  // R10
  rise_fall_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise_pulse && fall_pulse));

  // R10
  rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |-> (filt_level && !$past(filt_level)));

  // R10
  fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |-> (!filt_level && $past(filt_level)));

endmodule

// File: tb/pin_noise_filter_bench.sv
`timescale 1ns/1ps
module pin_noise_filter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] ps = 3'd0;
  logic       filt, rise, fall;

  pin_noise_filter u_pin_noise_filter (
    .clk          (clk),
    .rst          (rst),
    .din_raw      (din),
    .mode_sel     (mode),
    .prescale_sel (ps),
    .filt_level   (filt),
    .rise_pulse   (rise),
    .fall_pulse   (fall)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    up;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cfg_p  = 0;
  bit   done   = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int divv();
    return 2 << ps;
  endfunction

  function automatic int next_tick(input int tmin);
    int t;
    t = cfg_p + 1 + divv();
    while (t < tmin) t += divv();
    return t;
  endfunction

  task automatic set_cfg(input logic [1:0] m, input logic [2:0] p);
    @(negedge clk);
    mode  = m;
    ps    = p;
    cfg_p = cyc;
  endtask

  task automatic set_din(input logic v, output int qc);
    @(negedge clk);
    din = v;
    qc  = cyc;
  endtask

  task automatic push(input int at, input bit up, input string tag);
    exp_t e;
    e.at = at; e.up = up; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string tag, input bit lvl);
    idle(40);
    check(q.size() == 0, tag, q.size(), 0);
    check(filt == lvl, tag, filt, lvl);
  endtask

  // Monitor: pops expected strobes as the design produces them
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rise && fall) check(1'b0, "R10 both strobes", 1, 0);
      if (rise || fall) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected strobe at cycle", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.at == cyc, {e.tag, " strobe cycle"}, cyc, e.at);
          check(rise == e.up, {e.tag, " strobe direction"}, rise, e.up);
          check(filt == e.up, {e.tag, " level with strobe"}, filt, e.up);
        end
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int qa, qb, t1;
    // R9 reset state, with the input high while reset is held
    din = 1'b1;
    idle(5);
    check(filt == 1'b0, "R9 level in reset", filt, 0);
    check(rise == 1'b0 && fall == 1'b0, "R9 strobes in reset", rise | fall, 0);
    din = 1'b0;
    rst = 1'b0;
    cfg_p = cyc;
    idle(6);
    check(filt == 1'b0, "R9 level after reset", filt, 0);

    // R8 two-sample, divide by 2
    set_cfg(2'b00, 3'd0);
    idle(10);
    set_din(1'b1, qa);
    set_din(1'b0, qb);
    idle(12);
    check(filt == 1'b0, "R8 one-clock pulse rejected", filt, 0);
    set_din(1'b1, qa);
    idle(3);
    set_din(1'b0, qb);
    push(next_tick(qa + 3) + 2, 1'b1, "R8 four-clock pulse rise");
    push(next_tick(qb + 3) + 2, 1'b0, "R8 four-clock pulse fall");
    drain("R8", 1'b0);

    // R3 two-sample, divide by 4 (R1 period)
    set_cfg(2'b00, 3'd1);
    idle(12);
    set_din(1'b1, qa);
    push(next_tick(qa + 3) + 4, 1'b1, "R3 R1 two-sample rise");
    idle(20);
    set_din(1'b0, qa);
    push(next_tick(qa + 3) + 4, 1'b0, "R3 R1 two-sample fall");
    drain("R3", 1'b0);

    // R4 three-sample, divide by 4
    set_cfg(2'b01, 3'd1);
    idle(16);
    set_din(1'b1, qa);
    idle(5);
    set_din(1'b0, qb);
    idle(20);
    check(filt == 1'b0, "R4 two-tick pulse rejected", filt, 0);
    set_din(1'b1, qa);
    push(next_tick(qa + 3) + 8, 1'b1, "R4 three-sample rise");
    idle(30);
    set_din(1'b0, qa);
    push(next_tick(qa + 3) + 8, 1'b0, "R4 three-sample fall");
    drain("R4", 1'b0);

    // R5 continuous, divide by 8, clean step
    set_cfg(2'b10, 3'd2);
    idle(20);
    set_din(1'b1, qa);
    push(next_tick(qa + 3) + 8, 1'b1, "R5 continuous clean rise");
    idle(30);
    // R6 noise sample on a half-rate edge between ticks
    set_din(1'b0, qa);
    t1 = next_tick(qa + 3);
    while (cyc != t1 + 1) @(negedge clk);
    din = 1'b1;
    @(negedge clk);
    din = 1'b0;
    push(t1 + 16, 1'b0, "R6 continuous delayed fall");
    drain("R6", 1'b0);

    // R7 bypass, R2 synchronizer latency, R10 back-to-back strobes
    set_cfg(2'b11, 3'd0);
    idle(5);
    set_din(1'b1, qa);
    push(qa + 3, 1'b1, "R7 R2 bypass rise");
    idle(5);
    set_din(1'b0, qa);
    push(qa + 3, 1'b0, "R7 bypass fall");
    set_din(1'b1, qb);
    push(qb + 3, 1'b1, "R10 bypass one-clock pulse rise");
    set_din(1'b0, qb);
    push(qb + 3, 1'b0, "R10 bypass one-clock pulse fall");
    drain("R7", 1'b0);

    // R11 configuration change discards a pending sample
    set_cfg(2'b00, 3'd3);
    idle(40);
    set_din(1'b1, qa);
    t1 = next_tick(qa + 3);
    while (cyc != t1) @(negedge clk);
    set_cfg(2'b00, 3'd2);
    push(next_tick(qa + 3) + 8, 1'b1, "R11 rise after history cleared");
    drain("R11", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule